// File: doc/BRIEF.md
# Two-Line Prefetching Read Buffer

This block sits on the read path between the bus masters and a memory controller. It keeps two lines of four doublewords, each line with its own tag and valid flag, and answers any master read that falls in a resident line in the same cycle the read is presented. A read that matches neither line makes the block fetch the whole line from memory, whatever the burst length of the read. The master read stays stalled until the line is in place, and is then answered from the buffer.

When the read-ahead control input is high, the block also fetches the line that follows the one being read. This happens only for master bursts of two or more doublewords, and only when that following line is not already held. The fetch starts as soon as the demanded doubleword has been handed over, whether that read hit at once or first needed a demand fill. A prefetch always replaces the line that is not being read. Any other choice of victim is made by least-recent use. A write seen on the snoop port drops any line whose tag it matches.

Top module: `lpb_top`

## Requirements
- R1: After reset both lines are invalid, `fillReq` is low and `rdReady` is low, so the first read of any address misses.
- R2: A read whose line address (`rdAddr` without its two low bits) matches a valid tag gets `rdReady` high in the same cycle as `rdReq`, and `rdData` carries the doubleword selected by `rdAddr[1:0]`.
- R3: A read that misses raises `fillReq` in the next cycle with `fillLine` equal to the read's line address, held steady until the fill ends. Memory returns four `fillValid` beats in word order 0,1,2,3. `fillReq` falls at the edge that takes the fourth beat, and the stalled read is answered in the cycle after that.
- R4: A miss fills the whole line even for a single-doubleword read, so the other three words of that line then hit with no further fill.
- R5: With `raEnable` high, a missing read of burst length two or more is followed, once it has been answered, by a fill of the next line (line address plus one).
- R6: A read with burst length 1 never starts a prefetch.
- R7: With `raEnable` high, a hit of burst length two or more starts a fill of the next line only when that line is not already valid in the buffer.
- R8: With `raEnable` low, only demand fills occur, and the two lines hold the two most recently used demand lines: a third line replaces the less recently read one.
- R9: A prefetch fills the way other than the one holding the line just read, so that line still hits afterwards.
- R10: A pulse on `wrStrobe` whose `wrLine` matches a valid tag invalidates that line, so the next read of it misses. A non-matching write leaves both lines resident.
- R11: A read that misses while a prefetch is in flight waits. Its demand fill is requested only after the prefetch fill has completed.
- R12: While a prefetch is in flight, reads of the other resident line are still answered with zero wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| raEnable | input | 1 | Read-ahead enable |
| rdReq | input | 1 | Master read request, held until `rdReady` |
| rdAddr | input | ADDR_W (22) | Doubleword address of the read |
| rdBurst | input | BURST_W (3) | Burst length of the master access in doublewords |
| rdReady | output | 1 | Read data valid this cycle |
| rdData | output | DATA_W (32) | Read data |
| wrStrobe | input | 1 | Write seen on the bus, one cycle |
| wrLine | input | LINE_W (20) | Line address of the observed write |
| fillReq | output | 1 | Line fill request, high for the whole fill |
| fillLine | output | LINE_W (20) | Line address being filled |
| fillValid | input | 1 | One fill doubleword present on `fillData` |
| fillData | input | DATA_W (32) | Fill data |

## Verification
The hardest state to reach is a prefetch still in flight while the master already issues further reads. One read must hit the other resident line, and another must miss and be made to wait behind the prefetch. The bench gets there by raising the memory model's latency for that scenario. It then issues a two-doubleword miss, so that a prefetch follows the demand fill, and presents the follow-up reads while `fillReq` is still up for the next line. The fill order recorded by the memory model shows whether the demand fill waited for the prefetch.

// File: rtl/lpb_pkg.sv
package lpb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DEMAND,
    ST_PREFETCH
  } lpbState_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic fillStart;  // target way becomes invalid, fill begins
    logic fillWrite;  // one fill beat to store
    logic fillDone;   // last beat, tag may become valid
    logic isDemand;   // fill in progress or starting is a demand fill
    logic fillWay;    // way being filled
    logic touch;      // a read was answered this cycle
    logic touchWay;   // way that answered it
  } lpbStrobe_t;

endpackage

// File: rtl/lpb_dpath.sv
module lpb_dpath
  import lpb_pkg::*;
#(
  parameter int LINE_W     = 20,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  localparam int WSEL_W    = $clog2(LINE_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINE_W-1:0] rdLine,
  input  logic [WSEL_W-1:0] rdWord,
  input  logic              wrStrobe,
  input  logic [LINE_W-1:0] wrLine,
  input  logic [LINE_W-1:0] fillLine,
  input  logic              fillActive,
  input  logic [WSEL_W-1:0] beatIdx,
  input  logic [DATA_W-1:0] fillData,
  input  lpbStrobe_t        strb,
  output logic              hit,
  output logic              hitWay,
  output logic              nextPresent,
  output logic              lruWay,
  output logic [DATA_W-1:0] rdData
);

  localparam int WAYS = 2;

  logic [DATA_W-1:0] store [WAYS][LINE_WORDS];
  logic [LINE_W-1:0] tagQ  [WAYS];
  logic [WAYS-1:0]   validQ;
  logic [WAYS-1:0]   hitVec;
  logic [WAYS-1:0]   nextVec;
  logic [WAYS-1:0]   wrVec;
  logic              killQ;
  logic              lruQ;
  logic [LINE_W-1:0] nextLine;

  assign nextLine = rdLine + LINE_W'(1);

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hitVec[w]  = validQ[w] && (tagQ[w] == rdLine);
    assign nextVec[w] = validQ[w] && (tagQ[w] == nextLine);
    assign wrVec[w]   = validQ[w] && (tagQ[w] == wrLine);
  end

  assign hit         = |hitVec;
  assign hitWay      = hitVec[1];
  assign nextPresent = |nextVec;
  assign lruWay      = lruQ;
  assign rdData      = store[hitWay][rdWord];

  // Line storage, written one beat at a time
  always_ff @(posedge clk) begin
    if (strb.fillWrite) store[strb.fillWay][beatIdx] <= fillData;
  end

  // A write to the line in flight stops it from becoming valid
  always_ff @(posedge clk) begin
    if (rst || strb.fillStart) killQ <= 1'b0;
    else if (fillActive && wrStrobe && (wrLine == fillLine)) killQ <= 1'b1;
  end

  // Tags and valid flags
  always_ff @(posedge clk) begin
    if (rst) begin
      validQ <= '0;
      for (int w = 0; w < WAYS; w++) tagQ[w] <= '0;
    end else begin
      for (int w = 0; w < WAYS; w++) begin
        if (strb.fillStart && (strb.fillWay == 1'(w))) begin
          validQ[w] <= 1'b0;
        end else if (strb.fillDone && (strb.fillWay == 1'(w))) begin
          validQ[w] <= !killQ && !(wrStrobe && (wrLine == fillLine));
          tagQ[w]   <= fillLine;
        end else if (wrStrobe && wrVec[w]) begin
          validQ[w] <= 1'b0;
        end
      end
    end
  end

  // Recency: demand fills and answered reads count as use, prefetches do not
  always_ff @(posedge clk) begin
    if (rst) lruQ <= 1'b0;
    else if (strb.fillDone && strb.isDemand) lruQ <= ~strb.fillWay;
    else if (strb.touch) lruQ <= ~strb.touchWay;
  end

  // R2
  tag_unique_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hitVec));

  // R10
  snoop_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wrStrobe && wrVec[0] && !strb.fillDone && !strb.fillStart) |=> !validQ[0]);

endmodule

// File: rtl/lpb_ctrl.sv
module lpb_ctrl
  import lpb_pkg::*;
#(
  parameter int LINE_W     = 20,
  parameter int LINE_WORDS = 4,
  parameter int BURST_W    = 3,
  localparam int WSEL_W    = $clog2(LINE_WORDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               raEnable,
  input  logic               rdReq,
  input  logic [BURST_W-1:0] rdBurst,
  input  logic [LINE_W-1:0]  rdLine,
  input  logic               hit,
  input  logic               hitWay,
  input  logic               nextPresent,
  input  logic               lruWay,
  input  logic               fillValid,
  output logic               rdReady,
  output logic               fillReq,
  output logic [LINE_W-1:0]  fillLine,
  output logic [WSEL_W-1:0]  beatIdx,
  output lpbStrobe_t         strb
);

  lpbState_t         state;
  logic [LINE_W-1:0] lineQ;
  logic              wayQ;
  logic [WSEL_W-1:0] beatQ;
  logic              idleHit;
  logic              idleMiss;
  logic              wantAhead;
  logic              lastBeat;

  assign wantAhead = raEnable && (rdBurst >= BURST_W'(2)) && !nextPresent;
  assign idleHit   = (state == ST_IDLE) && rdReq && hit;
  assign idleMiss  = (state == ST_IDLE) && rdReq && !hit;
  assign rdReady   = rdReq && hit && (state != ST_DEMAND);
  assign fillReq   = (state != ST_IDLE);
  assign fillLine  = lineQ;
  assign beatIdx   = beatQ;
  assign lastBeat  = fillReq && fillValid && (beatQ == WSEL_W'(LINE_WORDS - 1));

  always_comb begin
    strb           = '0;
    strb.touch     = rdReady;
    strb.touchWay  = hitWay;
    strb.fillStart = idleMiss || (idleHit && wantAhead);
    strb.fillWrite = fillReq && fillValid;
    strb.fillDone  = lastBeat;
    if (state == ST_IDLE) begin
      strb.fillWay  = idleMiss ? lruWay : ~hitWay;
      strb.isDemand = idleMiss;
    end else begin
      strb.fillWay  = wayQ;
      strb.isDemand = (state == ST_DEMAND);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      lineQ <= '0;
      wayQ  <= 1'b0;
      beatQ <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (strb.fillStart) begin
            state <= idleMiss ? ST_DEMAND : ST_PREFETCH;
            lineQ <= idleMiss ? rdLine : rdLine + LINE_W'(1);
            wayQ  <= strb.fillWay;
            beatQ <= '0;
          end
        end
        default: begin
          if (fillValid) begin
            beatQ <= beatQ + WSEL_W'(1);
            if (lastBeat) state <= ST_IDLE;
          end
        end
      endcase
    end
  end

  // R3
  miss_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (!fillReq && rdReq && !hit) |=> (fillReq && fillLine == $past(rdLine)));

  // R3
  fill_line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fillReq && $past(fillReq)) |-> $stable(fillLine));

  // R6
  single_no_prefetch_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PREFETCH && $past(state) == ST_IDLE)
      |-> ($past(rdBurst) >= BURST_W'(2) && $past(raEnable)));

  // R9
  victim_not_read_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PREFETCH && $past(state) == ST_IDLE) |-> (wayQ != $past(hitWay)));

endmodule

// File: rtl/lpb_top.sv
module lpb_top
  import lpb_pkg::*;
#(
  parameter int ADDR_W     = 22,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int BURST_W    = 3,
  localparam int WSEL_W    = $clog2(LINE_WORDS),
  localparam int LINE_W    = ADDR_W - WSEL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               raEnable,
  input  logic               rdReq,
  input  logic [ADDR_W-1:0]  rdAddr,
  input  logic [BURST_W-1:0] rdBurst,
  output logic               rdReady,
  output logic [DATA_W-1:0]  rdData,
  input  logic               wrStrobe,
  input  logic [LINE_W-1:0]  wrLine,
  output logic               fillReq,
  output logic [LINE_W-1:0]  fillLine,
  input  logic               fillValid,
  input  logic [DATA_W-1:0]  fillData
);

  logic [LINE_W-1:0] rdLine;
  logic [WSEL_W-1:0] rdWord;
  logic [WSEL_W-1:0] beatIdx;
  logic              hit;
  logic              hitWay;
  logic              nextPresent;
  logic              lruWay;
  lpbStrobe_t        strb;

  assign rdLine = rdAddr[ADDR_W-1:WSEL_W];
  assign rdWord = rdAddr[WSEL_W-1:0];

  lpb_ctrl #(
    .LINE_W(LINE_W), .LINE_WORDS(LINE_WORDS), .BURST_W(BURST_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .raEnable(raEnable), .rdReq(rdReq), .rdBurst(rdBurst),
    .rdLine(rdLine), .hit(hit), .hitWay(hitWay), .nextPresent(nextPresent),
    .lruWay(lruWay), .fillValid(fillValid), .rdReady(rdReady), .fillReq(fillReq),
    .fillLine(fillLine), .beatIdx(beatIdx), .strb(strb)
  );

  lpb_dpath #(
    .LINE_W(LINE_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS)
  ) u_dpath (
    .clk(clk), .rst(rst), .rdLine(rdLine), .rdWord(rdWord), .wrStrobe(wrStrobe),
    .wrLine(wrLine), .fillLine(fillLine), .fillActive(fillReq), .beatIdx(beatIdx),
    .fillData(fillData), .strb(strb), .hit(hit), .hitWay(hitWay),
    .nextPresent(nextPresent), .lruWay(lruWay), .rdData(rdData)
  );

endmodule

// File: tb/lpb_top_test.sv
`timescale 1ns/1ps
module lpb_top_test;

  localparam int ADDR_W = 22;
  localparam int LINE_W = 20;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              raEnable = 1'b0;
  logic              rdReq = 1'b0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [2:0]        rdBurst = 3'd1;
  logic              rdReady;
  logic [31:0]       rdData;
  logic              wrStrobe = 1'b0;
  logic [LINE_W-1:0] wrLine = '0;
  logic              fillReq;
  logic [LINE_W-1:0] fillLine;
  logic              fillValid = 1'b0;
  logic [31:0]       fillData = '0;

  int checks = 0;
  int fails = 0;
  int fillCount = 0;
  logic [LINE_W-1:0] lastFill = '0;
  logic [LINE_W-1:0] prevFill = '0;
  int memDelay = 2;

  always #2 clk = ~clk;

  lpb_top uut (
    .clk(clk), .rst(rst), .raEnable(raEnable), .rdReq(rdReq), .rdAddr(rdAddr),
    .rdBurst(rdBurst), .rdReady(rdReady), .rdData(rdData), .wrStrobe(wrStrobe),
    .wrLine(wrLine), .fillReq(fillReq), .fillLine(fillLine), .fillValid(fillValid),
    .fillData(fillData)
  );

  function automatic logic [31:0] memWord(input logic [ADDR_W-1:0] dw);
    return 32'(dw) ^ 32'hC300_0000;
  endfunction

  // Memory model: answers each fill with four beats in word order
  initial begin
    forever begin
      @(negedge clk);
      if (fillReq) begin
        prevFill = lastFill;
        lastFill = fillLine;
        fillCount++;
        repeat (memDelay) @(negedge clk);
        for (int b = 0; b < 4; b++) begin
          fillValid = 1'b1;
          fillData  = memWord({lastFill, 2'(b)});
          @(negedge clk);
        end
        fillValid = 1'b0;
      end
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic doRead(input logic [23:0] byteAddr, input int burst,
                        input bit expHit, input string req);
    int waits = 0;
    @(negedge clk);
    rdAddr  = byteAddr[23:2];
    rdBurst = 3'(burst);
    rdReq   = 1'b1;
    #1;
    while (!rdReady && waits < 1000) begin
      @(negedge clk);
      #1;
      waits++;
    end
    check("R2", "read data", rdData, memWord(byteAddr[23:2]));
    check(req, "zero-wait hit", 32'(waits == 0), 32'(expHit));
    @(negedge clk);
    rdReq = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    while (fillReq) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic snoopWrite(input logic [LINE_W-1:0] ln);
    @(negedge clk);
    wrStrobe = 1'b1;
    wrLine   = ln;
    @(negedge clk);
    wrStrobe = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    check("R1", "fillReq after reset", 32'(fillReq), 32'd0);
    check("R1", "rdReady after reset", 32'(rdReady), 32'd0);
  endtask

  task automatic t_single_miss();
    int base = fillCount;
    raEnable = 1'b1;
    doRead(24'h000104, 1, 1'b0, "R1");
    settle();
    check("R3", "fill line", 32'(lastFill), 32'h10);
    check("R6", "fills after single read", 32'(fillCount - base), 32'd1);
    doRead(24'h000100, 1, 1'b1, "R4");
    doRead(24'h000108, 1, 1'b1, "R4");
    doRead(24'h00010C, 1, 1'b1, "R4");
    check("R4", "no extra fill", 32'(fillCount - base), 32'd1);
  endtask

  task automatic t_burst_miss();
    int base = fillCount;
    doRead(24'h000200, 4, 1'b0, "R3");
    settle();
    check("R5", "fills after burst miss", 32'(fillCount - base), 32'd2);
    check("R5", "prefetched line", 32'(lastFill), 32'h21);
    doRead(24'h000210, 1, 1'b1, "R5");
  endtask

  task automatic t_hit_ahead();
    int base = fillCount;
    doRead(24'h000214, 2, 1'b1, "R7");
    settle();
    check("R7", "prefetch on hit", 32'(lastFill), 32'h22);
    doRead(24'h000220, 2, 1'b1, "R7");
    settle();
    check("R7", "second prefetch", 32'(lastFill), 32'h23);
    check("R7", "fill count", 32'(fillCount - base), 32'd2);
    doRead(24'h000228, 2, 1'b1, "R7");
    settle();
    check("R7", "no fill when next present", 32'(fillCount - base), 32'd2);
    doRead(24'h00022C, 1, 1'b1, "R9");
    doRead(24'h000230, 1, 1'b1, "R9");
  endtask

  task automatic t_no_ahead();
    int base = fillCount;
    raEnable = 1'b0;
    doRead(24'h000300, 4, 1'b0, "R8");
    settle();
    check("R8", "no prefetch when disabled", 32'(fillCount - base), 32'd1);
    doRead(24'h000400, 4, 1'b0, "R8");
    doRead(24'h000300, 1, 1'b1, "R8");
    doRead(24'h000400, 1, 1'b1, "R8");
    doRead(24'h000500, 1, 1'b0, "R8");
    doRead(24'h000400, 1, 1'b1, "R8");
    doRead(24'h000300, 1, 1'b0, "R8");
    settle();
    check("R8", "demand fill count", 32'(fillCount - base), 32'd4);
  endtask

  task automatic t_snoop();
    snoopWrite(20'h40);
    doRead(24'h000400, 1, 1'b0, "R10");
    snoopWrite(20'h99);
    doRead(24'h000300, 1, 1'b1, "R10");
    doRead(24'h000404, 1, 1'b1, "R10");
  endtask

  task automatic t_busy_prefetch();
    memDelay = 20;
    raEnable = 1'b1;
    doRead(24'h000700, 2, 1'b0, "R5");
    #1;
    check("R11", "prefetch in flight", 32'(fillReq), 32'd1);
    check("R11", "prefetch line", 32'(fillLine), 32'h71);
    doRead(24'h000704, 1, 1'b1, "R12");
    doRead(24'h000800, 1, 1'b0, "R11");
    settle();
    check("R11", "demand after prefetch", 32'(lastFill), 32'h80);
    check("R11", "prefetch completed first", 32'(prevFill), 32'h71);
    memDelay = 2;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_single_miss();
    t_burst_miss();
    t_hit_ahead();
    t_no_ahead();
    t_snoop();
    t_busy_prefetch();
    summary();
  end

endmodule